// File: doc/BRIEF.md
# Software-Increment Chained Event Counter Bank

This block holds a small bank of general-purpose event counters that are stepped by software rather than by hardware event lines. Software writes a bitmask to an increment register; each counter named in the mask advances by one, provided the bank is globally switched on, that counter is enabled, and its event-type register holds the software-increment code. All counters touched by one such write update in the same clock edge.

Counters are 32 bits wide. An even-numbered counter and the odd counter just above it can be joined into one 64-bit count by programming the chain code into the odd counter's event type. When the low half then wraps, the carry steps the high half, and the overflow flag is raised only for the high half when that half wraps in turn. An unjoined counter that wraps raises its own flag. Overflow flags stay set until software clears them with a write-one-to-clear. A plain address/data register port reads and writes every counter, event type, enable and flag.

Top module: `swinc_counter_bank`

## Requirements
- R1: An increment write (address 0x04) whose data is zero changes no counter and no overflow flag.
- R2: While the global enable (bit 0 at address 0x00) is clear, an increment write changes no counter and no overflow flag.
- R3: A counter whose enable bit is clear is not advanced; address 0x01 sets enable bits for each one written, address 0x02 clears them, and either address reads back the enable mask.
- R4: A selected counter advances only if its event type (address 0x40 + index) equals the software-increment code 0x00; any other type, including the chain code 0x1E, leaves it unaffected by its own mask bit.
- R5: Mask bits at indices at or above the counter count (the cycle-counter index and beyond) have no effect.
- R6: An advancing counter steps by exactly one and wraps from 0xFFFFFFFF to zero; if it is not the low half of a chained pair, its overflow bit i (read at address 0x03) is set on that wrap.
- R7: When even counter i wraps and counter i+1 holds the chain code, counter i+1 steps by one in the same cycle and overflow bit i is not set.
- R8: When that carried-into high counter itself wraps, overflow bit i+1 is set.
- R9: Overflow bits are sticky: they are raised only by an increment write and cleared only by writing a one to the same bit at address 0x03.
- R10: After reset every counter, enable, event type, the global enable and all overflow bits read zero; a counter written at address 0x20 + index reads back the written value on the following cycle.
- R11: Every counter advanced by one increment write, including a chained high half, changes in the single clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one write per asserted cycle |
| reg_addr | input | 7 | Register address: bits 6:5 page, bits 4:0 offset or counter index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr, combinational |

## Verification
The two functions that meet in one cycle are the carry from a wrapping low half into its chained high half and the independent wrap of an unchained counter, both triggered by the same increment write. The bench presets a chained pair's low half and a separate counter to all ones, then issues one mask naming both (plus the chained high counter's own bit), and judges that the high half stepped once, both wrapped counters read zero, and only the unchained counter's overflow bit is set. A second case presets both halves of a pair to all ones so that the carry and the high-half overflow fall in the same edge.

// File: rtl/swinc_pkg.sv
package swinc_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 7;
   localparam int unsigned IDX_W  = 5;

   typedef enum logic [1:0] {
      PG_CTRL = 2'b00,
      PG_CNT  = 2'b01,
      PG_EVT  = 2'b10,
      PG_RSVD = 2'b11
   } page_e;

   localparam logic [IDX_W-1:0] OFS_GEN    = 5'd0;
   localparam logic [IDX_W-1:0] OFS_ENSET  = 5'd1;
   localparam logic [IDX_W-1:0] OFS_ENCLR  = 5'd2;
   localparam logic [IDX_W-1:0] OFS_OVF    = 5'd3;
   localparam logic [IDX_W-1:0] OFS_SWINC  = 5'd4;

   function automatic logic hits(input logic [ADDR_W-1:0] a, input page_e pg,
                                 input logic [IDX_W-1:0] ofs);
      return (a[ADDR_W-1:IDX_W] == pg) && (a[IDX_W-1:0] == ofs);
   endfunction
endpackage

// File: rtl/swinc_regs.sv
module swinc_regs
   import swinc_pkg::*;
#(
   parameter int unsigned NUM_CNT = 6,
   parameter int unsigned EVT_W   = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   input  logic [NUM_CNT-1:0]              ovf_set,
   output logic                            gen_q,
   output logic [NUM_CNT-1:0]              en_q,
   output logic [NUM_CNT-1:0][EVT_W-1:0]   evt_q,
   output logic [NUM_CNT-1:0]              ovf_q
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= 1'b0;
         en_q  <= '0;
      end else if (wr) begin
         if (hits(addr, PG_CTRL, OFS_GEN))   gen_q <= wdata[0];
         if (hits(addr, PG_CTRL, OFS_ENSET)) en_q  <= en_q | wdata[NUM_CNT-1:0];
         if (hits(addr, PG_CTRL, OFS_ENCLR)) en_q  <= en_q & ~wdata[NUM_CNT-1:0];
      end
   end

   logic [NUM_CNT-1:0] ovf_clr;
   assign ovf_clr = (wr && hits(addr, PG_CTRL, OFS_OVF)) ? wdata[NUM_CNT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            evt_q[i] <= '0;
         else if (wr && hits(addr, PG_EVT, IDX_W'(i)))
            evt_q[i] <= wdata[EVT_W-1:0];
      end
   end
endmodule

// File: rtl/swinc_step.sv
module swinc_step #(
   parameter int unsigned NUM_CNT    = 6,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned EVT_W      = 10,
   parameter int unsigned SWINC_CODE = 'h00,
   parameter int unsigned CHAIN_CODE = 'h1E
) (
   input  logic                            fire,
   input  logic [NUM_CNT-1:0]              mask,
   input  logic                            gen,
   input  logic [NUM_CNT-1:0]              en,
   input  logic [NUM_CNT-1:0][EVT_W-1:0]   evt,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
   output logic [NUM_CNT-1:0]              inc,
   output logic [NUM_CNT-1:0]              ovf_set
);
   localparam logic [EVT_W-1:0] SW_EVT = EVT_W'(SWINC_CODE);
   localparam logic [EVT_W-1:0] CH_EVT = EVT_W'(CHAIN_CODE);

   logic [NUM_CNT-1:0] sel;
   logic [NUM_CNT-1:0] at_max;
   logic [NUM_CNT-1:0] carry;
   logic [NUM_CNT-1:0] hi_linked;
   logic [NUM_CNT-1:0] quiet;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
      assign sel[i]    = fire & gen & mask[i] & en[i] & (evt[i] == SW_EVT);
      assign at_max[i] = &cnt[i];

      if (i % 2 == 1) begin : g_odd
         assign hi_linked[i] = (evt[i] == CH_EVT);
         assign carry[i]     = hi_linked[i] & sel[i-1] & at_max[i-1];
         assign quiet[i]     = 1'b0;
      end else if (i + 1 < NUM_CNT) begin : g_even_pair
         assign hi_linked[i] = 1'b0;
         assign carry[i]     = 1'b0;
         assign quiet[i]     = (evt[i+1] == CH_EVT);
      end else begin : g_even_lone
         assign hi_linked[i] = 1'b0;
         assign carry[i]     = 1'b0;
         assign quiet[i]     = 1'b0;
      end

      assign inc[i]     = sel[i] | carry[i];
      assign ovf_set[i] = inc[i] & at_max[i] & ~quiet[i];
   end
endmodule

// File: rtl/swinc_cnt_slice.sv
module swinc_cnt_slice #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/swinc_counter_bank.sv
module swinc_counter_bank
   import swinc_pkg::*;
#(
   parameter int unsigned NUM_CNT    = 6,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned EVT_W      = 10,
   parameter int unsigned SWINC_CODE = 'h00,
   parameter int unsigned CHAIN_CODE = 'h1E
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [6:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata
);
   if (NUM_CNT < 1 || NUM_CNT >= (1 << IDX_W))
      begin : g_bad_num  $error("NUM_CNT must lie in 1..31"); end
   if (CNT_W < 2 || CNT_W > DATA_W)
      begin : g_bad_cnt  $error("CNT_W must lie in 2..32"); end
   if (EVT_W < 1 || EVT_W > DATA_W)
      begin : g_bad_evt  $error("EVT_W must lie in 1..32"); end
   if (SWINC_CODE == CHAIN_CODE || CHAIN_CODE >= (64'd1 << EVT_W) || SWINC_CODE >= (64'd1 << EVT_W))
      begin : g_bad_code $error("event codes must differ and fit EVT_W"); end

   logic                          gen_q;
   logic [NUM_CNT-1:0]            en_q;
   logic [NUM_CNT-1:0]            ovf_q;
   logic [NUM_CNT-1:0]            ovf_set;
   logic [NUM_CNT-1:0]            inc;
   logic [NUM_CNT-1:0][EVT_W-1:0] evt_q;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
   logic                          fire;
   logic [IDX_W-1:0]              idx;
   logic unused_in;

   assign idx       = reg_addr[IDX_W-1:0];
   assign fire      = reg_wr && hits(reg_addr, PG_CTRL, OFS_SWINC);
   assign unused_in = ^reg_wdata;

   swinc_regs #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .ovf_set(ovf_set), .gen_q(gen_q), .en_q(en_q), .evt_q(evt_q), .ovf_q(ovf_q)
   );

   swinc_step #(
      .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W),
      .SWINC_CODE(SWINC_CODE), .CHAIN_CODE(CHAIN_CODE)
   ) u_step (
      .fire(fire), .mask(reg_wdata[NUM_CNT-1:0]), .gen(gen_q), .en(en_q),
      .evt(evt_q), .cnt(cnt_q), .inc(inc), .ovf_set(ovf_set)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      swinc_cnt_slice #(.CNT_W(CNT_W)) u_slice (
         .clk(clk), .rst_n(rst_n),
         .load(reg_wr && hits(reg_addr, PG_CNT, IDX_W'(i))),
         .load_val(reg_wdata[CNT_W-1:0]),
         .inc(inc[i]),
         .cnt_q(cnt_q[i])
      );
   end

   always_comb begin
      reg_rdata = '0;
      unique case (page_e'(reg_addr[ADDR_W-1:IDX_W]))
         PG_CTRL: begin
            if (idx == OFS_GEN)                         reg_rdata[0] = gen_q;
            if (idx == OFS_ENSET || idx == OFS_ENCLR)   reg_rdata[NUM_CNT-1:0] = en_q;
            if (idx == OFS_OVF)                         reg_rdata[NUM_CNT-1:0] = ovf_q;
         end
         PG_CNT: begin
            for (int k = 0; k < NUM_CNT; k++)
               if (idx == IDX_W'(k)) reg_rdata[CNT_W-1:0] = cnt_q[k];
         end
         PG_EVT: begin
            for (int k = 0; k < NUM_CNT; k++)
               if (idx == IDX_W'(k)) reg_rdata[EVT_W-1:0] = evt_q[k];
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/swinc_bank_checker.sv
module swinc_bank_checker
   import swinc_pkg::*;
#(
   parameter int unsigned NUM_CNT    = 6,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned EVT_W      = 10,
   parameter int unsigned CHAIN_CODE = 'h1E
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_wr,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic [DATA_W-1:0]             reg_wdata,
   input logic                          gen_q,
   input logic [NUM_CNT-1:0]            ovf_q,
   input logic [NUM_CNT-1:0][EVT_W-1:0] evt_q,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
   logic sw_wr, clr_wr;
   assign sw_wr  = reg_wr && hits(reg_addr, PG_CTRL, OFS_SWINC);
   assign clr_wr = reg_wr && hits(reg_addr, PG_CTRL, OFS_OVF);

   assert_zero_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr && reg_wdata == '0 |=> $stable(cnt_q) && $stable(ovf_q));

   assert_global_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr && !gen_q |=> $stable(cnt_q) && $stable(ovf_q));

   assert_high_bits_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr && reg_wdata[NUM_CNT-1:0] == '0 |=> $stable(cnt_q) && $stable(ovf_q));

   assert_ovf_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> (ovf_q & ~$past(ovf_q)) == '0);

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_lane
      assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
         sw_wr |=> CNT_W'(cnt_q[i] - $past(cnt_q[i])) <= CNT_W'(1));

      assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_q[i] && !(clr_wr && reg_wdata[i]) |=> ovf_q[i]);

      if (i % 2 == 0 && i + 1 < NUM_CNT) begin : g_pair
         assert_chain_low_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sw_wr && evt_q[i+1] == EVT_W'(CHAIN_CODE) && !ovf_q[i] |=> !ovf_q[i]);
      end
   end
endmodule

bind swinc_counter_bank swinc_bank_checker #(
   .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W), .CHAIN_CODE(CHAIN_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .gen_q(gen_q), .ovf_q(ovf_q), .evt_q(evt_q), .cnt_q(cnt_q)
);

// File: tb/test_swinc_counter_bank.sv
module test_swinc_counter_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [6:0] A_GEN = 7'h00, A_ENS = 7'h01, A_ENC = 7'h02,
                          A_OVF = 7'h03, A_INC = 7'h04;
   localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

   always #4 clk = ~clk;

   swinc_counter_bank i_swinc_counter_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [6:0] a_cnt(input int i); return 7'h20 + 7'(i); endfunction
   function automatic logic [6:0] a_evt(input int i); return 7'h40 + 7'(i); endfunction

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic chk(input string req, input string what, input logic [6:0] a,
                      input logic [31:0] exp);
      logic [31:0] got;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1 got = reg_rdata;
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic t_reset();   // R10
      chk("R10", "counter0 after reset", a_cnt(0), 0);
      chk("R10", "counter5 after reset", a_cnt(5), 0);
      chk("R10", "enable after reset", A_ENS, 0);
      chk("R10", "overflow after reset", A_OVF, 0);
      chk("R10", "global enable after reset", A_GEN, 0);
      chk("R10", "event type after reset", a_evt(3), 0);
   endtask

   task automatic t_basic();   // R6, R11
      wr(A_GEN, 1); wr(A_ENS, 32'h3F);
      chk("R3", "enable set readback", A_ENC, 32'h3F);
      wr(A_INC, 32'h05);
      chk("R6", "counter0 stepped", a_cnt(0), 1);
      chk("R11", "counter2 stepped same edge", a_cnt(2), 1);
      chk("R6", "counter1 untouched", a_cnt(1), 0);
   endtask

   task automatic t_zero_mask();   // R1
      wr(A_INC, 0);
      chk("R1", "counter0 after zero mask", a_cnt(0), 1);
      chk("R1", "counter2 after zero mask", a_cnt(2), 1);
   endtask

   task automatic t_global_off();   // R2
      wr(A_GEN, 0); wr(A_INC, 32'h3F);
      chk("R2", "counter0 with bank off", a_cnt(0), 1);
      chk("R2", "counter4 with bank off", a_cnt(4), 0);
      wr(A_GEN, 1);
   endtask

   task automatic t_disabled();   // R3
      wr(A_ENC, 32'h08);
      chk("R3", "enable after clear", A_ENS, 32'h37);
      wr(A_INC, 32'h08);
      chk("R3", "disabled counter3", a_cnt(3), 0);
      wr(A_ENS, 32'h08);
   endtask

   task automatic t_evtype();   // R4
      wr(a_evt(4), 32'h11);
      chk("R4", "event type readback", a_evt(4), 32'h11);
      wr(A_INC, 32'h10);
      chk("R4", "counter4 other event", a_cnt(4), 0);
      wr(a_evt(4), 0);
   endtask

   task automatic t_high_mask();   // R5
      wr(A_INC, 32'hFFFF_FFC0);
      chk("R5", "counter0 after high bits", a_cnt(0), 1);
      chk("R5", "counter5 after high bits", a_cnt(5), 0);
   endtask

   task automatic t_wrap();   // R6, R9, R10
      wr(a_cnt(5), ALL1);
      chk("R10", "counter write readback", a_cnt(5), ALL1);
      wr(A_INC, 32'h20);
      chk("R6", "counter5 wrapped", a_cnt(5), 0);
      chk("R6", "overflow bit5", A_OVF, 32'h20);
      wr(A_OVF, 32'h01);
      chk("R9", "overflow kept by other-bit clear", A_OVF, 32'h20);
      wr(A_INC, 32'h01);
      chk("R9", "overflow kept over increment", A_OVF, 32'h20);
      wr(A_OVF, 32'h20);
      chk("R9", "overflow cleared", A_OVF, 0);
   endtask

   task automatic t_chain();   // R7, R4, R11
      wr(a_evt(1), 32'h1E);
      wr(a_cnt(0), 7); wr(a_cnt(1), 5);
      wr(A_INC, 32'h01);
      chk("R7", "low steps without carry", a_cnt(0), 8);
      chk("R7", "high unchanged without carry", a_cnt(1), 5);
      wr(a_cnt(0), ALL1); wr(a_cnt(2), ALL1);
      wr(A_INC, 32'h07);
      chk("R7", "low half wrapped", a_cnt(0), 0);
      chk("R4", "high half stepped once", a_cnt(1), 6);
      chk("R11", "unchained counter2 wrapped", a_cnt(2), 0);
      chk("R7", "only unchained overflow", A_OVF, 32'h04);
   endtask

   task automatic t_chain_hi_wrap();   // R8
      wr(A_OVF, 32'h3F);
      wr(a_cnt(0), ALL1); wr(a_cnt(1), ALL1);
      wr(A_INC, 32'h01);
      chk("R8", "low half zero", a_cnt(0), 0);
      chk("R8", "high half zero", a_cnt(1), 0);
      chk("R8", "overflow on high bit only", A_OVF, 32'h02);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_zero_mask();
      t_global_off();
      t_disabled();
      t_evtype();
      t_high_mask();
      t_wrap();
      t_chain();
      t_chain_hi_wrap();
      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule